// File: doc/BRIEF.md
# DMA Transfer Byte Counter

This block keeps track of how many bytes are still to be moved in a DMA transfer. Software programs a start length through a byte-wide register port, one byte lane per write. Issuing a command with its DMA bit set copies that start length into a down-counter. The data path then sends abstract byte and word strobes, which take one or two bytes off the remaining count. When the count reaches zero, a sticky flag is raised. Software can read the live count back through the same three lane addresses.

The counter is 24 bits wide. When the extended-feature input is low, it runs as a 16-bit counter. In that mode the top lane ignores writes and plays no part in loading or counting. A start value of zero means the longest possible transfer: 2^24 bytes with the extended features on, 2^16 bytes with them off. The start register has no reset, so a transfer length that has been programmed once can be reused after a hardware or software reset. After every reset the top lane address returns a fixed identification byte. It keeps doing so until software writes that lane with the extended features enabled.

Top module: `dma_byte_counter`

## Requirements
- R1: A write with `reg_wr_en` to address 0x0 sets start bits 7:0, and a write to 0x1 sets start bits 15:8. Writing the start value does not change the live count; the count changes only when a DMA command is issued.
- R2: A cycle with `cmd_valid`=1 and `cmd_dma`=1 loads the live count from the start value. A cycle with `cmd_valid`=1 and `cmd_dma`=0 leaves both the count and `count_zero` unchanged.
- R3: In a cycle with no load, `dec_byte`=1 takes 1 off the count, `dec_word`=1 takes 2 off, and both together take 3 off. The new count is in place after the clock edge that samples the strobes.
- R4: A start value that is zero after masking loads 2^24 when `feat_en`=1 and 2^16 when `feat_en`=0. In both cases lanes 0x0 and 0x1 read back as 0x00 and `count_zero` stays 0; after one byte strobe they read back as 0xFF.
- R5: With `feat_en`=0, a write to 0xE is ignored. A load then uses only start bits 15:0. A read of 0xE that is not showing the identification byte returns 0x00.
- R6: A reset leaves the start value unchanged. A DMA command issued after the reset reloads the value that was programmed before it.
- R7: `count_zero` goes to 1 on the edge at which a decrement takes a nonzero count to zero, and it then holds. It returns to 0 only on a load or a reset.
- R8: After a reset, reads of 0xE return ID_CODE (default 0x5A). This lasts until a write to 0xE is made with `feat_en`=1. After that, with `feat_en`=1, 0xE returns count bits 23:16.
- R9: A decrement larger than the remaining count leaves the count at zero; the count never wraps.
- R10: When a load and a decrement strobe arrive in the same cycle, the load wins and the strobe is dropped.
- R11: Reset sets the count to 0 and `count_zero` to 0, so lanes 0x0 and 0x1 read back as 0x00.
- R12: `reg_rd_data` is registered. It shows the lane selected by `reg_addr` at the previous clock edge, and any address other than 0x0, 0x1 and 0xE reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hardware or software) |
| feat_en | input | 1 | Extended features: enables the top count lane |
| reg_addr | input | 4 | Lane address for both reads and writes |
| reg_wr_en | input | 1 | Write strobe for the start value |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Registered read data |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_dma | input | 1 | DMA bit of the issued command |
| dec_byte | input | 1 | One byte transferred |
| dec_word | input | 1 | One 16-bit word transferred |
| count_zero | output | 1 | Sticky count-reached-zero flag |

## Verification
A load or a decrement takes effect at the clock edge that samples it, so `count_zero` can be checked at the falling edge straight after that cycle. Read data arrives one edge after the address is presented. For that reason the bench sets the address at a falling edge and samples `reg_rd_data` at the next falling edge, and it holds the count still while it reads all three lanes. The bench sweeps both feature settings and several start lengths, including zero and values of only a few bytes. It applies every mix of byte and word strobe, and it compares each step with a count model of its own that saturates at zero.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int LANE_W = 8;
  localparam int ADDR_W = 4;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // bytes removed by one cycle of strobes: 0..3
  function automatic logic [1:0] step_bytes(input logic b, input logic w);
    return {1'b0, b} + {w, 1'b0};
  endfunction
endpackage

// File: rtl/dbc_start_regs.sv
module dbc_start_regs
  import dbc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BASE_W = 16,
  parameter logic [(CNT_W/LANE_W)*ADDR_W-1:0] LANE_ADDRS = {4'hE, 4'h1, 4'h0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  addr_t            wr_addr,
  input  lane_t            wr_data,
  input  logic             feat_en,
  output logic [CNT_W-1:0] start_q,
  output logic             id_show
);
  localparam int NLANES = CNT_W / LANE_W;
  localparam int BASE_LANES = BASE_W / LANE_W;
  localparam int TOP_LANE = NLANES - 1;

  logic [NLANES-1:0] lane_we;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic hit;
    assign hit = wr_en && (wr_addr == LANE_ADDRS[i*ADDR_W +: ADDR_W]);
    if (i >= BASE_LANES) begin : g_ext
      assign lane_we[i] = hit && feat_en;
    end else begin : g_base
      assign lane_we[i] = hit;
    end
    // no reset: the programmed length survives resets
    always_ff @(posedge clk) begin
      if (lane_we[i]) start_q[i*LANE_W +: LANE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    id_show <= 1'b1;
    else if (lane_we[TOP_LANE]) id_show <= 1'b0;
  end
endmodule

// File: rtl/dbc_down_counter.sv
module dbc_down_counter
  import dbc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BASE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             feat_en,
  input  logic [CNT_W-1:0] start_q,
  input  logic             dec_byte,
  input  logic             dec_word,
  output logic [CNT_W:0]   cnt_q,
  output logic             zero_q
);
  localparam logic [CNT_W:0] MAX_FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] MAX_BASE = (CNT_W+1)'(1) << BASE_W;
  localparam logic [CNT_W:0] BASE_MASK = MAX_BASE - (CNT_W+1)'(1);

  logic [CNT_W:0] masked, load_val, amt, dec_next;

  always_comb begin
    masked = feat_en ? {1'b0, start_q} : ({1'b0, start_q} & BASE_MASK);
    if (masked == '0) load_val = feat_en ? MAX_FULL : MAX_BASE;
    else              load_val = masked;
    amt = {{(CNT_W-1){1'b0}}, step_bytes(dec_byte, dec_word)};
    dec_next = (cnt_q < amt) ? '0 : cnt_q - amt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      zero_q <= 1'b0;
    end else if (amt != '0) begin
      cnt_q <= dec_next;
      if (cnt_q != '0 && dec_next == '0) zero_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbc_read_port.sv
module dbc_read_port
  import dbc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BASE_W = 16,
  parameter logic [(CNT_W/LANE_W)*ADDR_W-1:0] LANE_ADDRS = {4'hE, 4'h1, 4'h0},
  parameter logic [LANE_W-1:0] ID_CODE = 8'h5A
) (
  input  logic             clk,
  input  logic             rst,
  input  addr_t            rd_addr,
  input  logic             feat_en,
  input  logic             id_show,
  input  logic [CNT_W-1:0] cnt_lanes,
  output lane_t            rd_data
);
  localparam int NLANES = CNT_W / LANE_W;
  localparam int BASE_LANES = BASE_W / LANE_W;

  lane_t sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NLANES; i++) begin
      if (rd_addr == LANE_ADDRS[i*ADDR_W +: ADDR_W]) begin
        if (i >= BASE_LANES) begin
          if (id_show)      sel = ID_CODE;
          else if (feat_en) sel = cnt_lanes[i*LANE_W +: LANE_W];
          else              sel = '0;
        end else begin
          sel = cnt_lanes[i*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter
  import dbc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BASE_W = 16,
  parameter logic [(CNT_W/LANE_W)*ADDR_W-1:0] LANE_ADDRS = {4'hE, 4'h1, 4'h0},
  parameter logic [LANE_W-1:0] ID_CODE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feat_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [LANE_W-1:0] reg_wr_data,
  output logic [LANE_W-1:0] reg_rd_data,
  input  logic              cmd_valid,
  input  logic              cmd_dma,
  input  logic              dec_byte,
  input  logic              dec_word,
  output logic              count_zero
);
  logic [CNT_W-1:0] start_q;
  logic [CNT_W:0]   cnt_q;
  logic             id_show;
  logic             load_req;

  assign load_req = cmd_valid && cmd_dma;

  dbc_start_regs #(.CNT_W(CNT_W), .BASE_W(BASE_W), .LANE_ADDRS(LANE_ADDRS)) u_start (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wr_data), .feat_en(feat_en), .start_q(start_q), .id_show(id_show)
  );

  dbc_down_counter #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_req), .feat_en(feat_en), .start_q(start_q),
    .dec_byte(dec_byte), .dec_word(dec_word), .cnt_q(cnt_q), .zero_q(count_zero)
  );

  dbc_read_port #(.CNT_W(CNT_W), .BASE_W(BASE_W), .LANE_ADDRS(LANE_ADDRS),
                  .ID_CODE(ID_CODE)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(reg_addr), .feat_en(feat_en), .id_show(id_show),
    .cnt_lanes(cnt_q[CNT_W-1:0]), .rd_data(reg_rd_data)
  );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
  parameter int CNT_W = 24,
  parameter logic [3:0] HI_ADDR = 4'hE
) (
  input logic           clk,
  input logic           rst,
  input logic           feat_en,
  input logic [3:0]     reg_addr,
  input logic           reg_wr_en,
  input logic           cmd_valid,
  input logic           cmd_dma,
  input logic           dec_byte,
  input logic           dec_word,
  input logic           count_zero,
  input logic [CNT_W:0] cnt_q,
  input logic           id_show,
  input logic           load_req
);
  // R7
  zero_clear_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_req |=> !count_zero);

  // R7
  zero_means_empty_chk: assert property (@(posedge clk) disable iff (rst)
    count_zero |-> cnt_q == '0);

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_req && (dec_byte || dec_word) |=> cnt_q != '0);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !load_req |=> cnt_q <= $past(cnt_q));

  // R3
  byte_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load_req && dec_byte && !dec_word && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

  // R2
  plain_cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_dma && !dec_byte && !dec_word |=> $stable(cnt_q) && $stable(count_zero));

  // R8
  id_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(id_show) |-> $past(reg_wr_en && feat_en && reg_addr == HI_ADDR));

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> cnt_q == '0 && !count_zero && id_show);
endmodule

bind dma_byte_counter dbc_checker #(.CNT_W(CNT_W), .HI_ADDR(LANE_ADDRS[(CNT_W/8)*4-1 -: 4])) u_chk (
  .clk(clk), .rst(rst), .feat_en(feat_en), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
  .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .dec_byte(dec_byte), .dec_word(dec_word),
  .count_zero(count_zero), .cnt_q(cnt_q), .id_show(id_show), .load_req(load_req)
);

// File: tb/dma_byte_counter_tb.sv
module dma_byte_counter_tb;
  localparam logic [7:0] ID = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic feat_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic cmd_valid = 1'b0, cmd_dma = 1'b0, dec_byte = 1'b0, dec_word = 1'b0;
  logic count_zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint mcnt;
  logic [23:0] mstart;
  bit mzero, mid;

  always #5 clk = ~clk;

  dma_byte_counter u_dut (
    .clk(clk), .rst(rst), .feat_en(feat_en), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .cmd_valid(cmd_valid),
    .cmd_dma(cmd_dma), .dec_byte(dec_byte), .dec_word(dec_word), .count_zero(count_zero)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 4'h0) mstart[7:0] = d;
    if (a == 4'h1) mstart[15:8] = d;
    if (a == 4'hE && feat_en) begin mstart[23:16] = d; mid = 0; end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rd_data;
  endtask

  task automatic pulse(input bit c, input bit dma, input bit b, input bit w);
    longint amt;
    cmd_valid = c; cmd_dma = dma; dec_byte = b; dec_word = w;
    @(negedge clk);
    cmd_valid = 0; cmd_dma = 0; dec_byte = 0; dec_word = 0;
    amt = longint'(b) + 2 * longint'(w);
    if (c && dma) begin
      mcnt = feat_en ? longint'(mstart) : longint'(mstart[15:0]);
      if (mcnt == 0) mcnt = feat_en ? (64'd1 << 24) : (64'd1 << 16);
      mzero = 0;
    end else if (amt != 0) begin
      if (mcnt != 0 && mcnt <= amt) mzero = 1;
      mcnt = (mcnt < amt) ? 0 : mcnt - amt;
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    longint hi;
    rd(4'h0, v); chk({tag, " lane0"}, longint'(v), mcnt & 255);
    rd(4'h1, v); chk({tag, " lane1"}, longint'(v), (mcnt >> 8) & 255);
    hi = mid ? longint'(ID) : (feat_en ? ((mcnt >> 16) & 255) : 0);
    rd(4'hE, v); chk({tag, " lane2"}, longint'(v), hi);
    chk({tag, " zero flag"}, longint'(count_zero), longint'(mzero));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mcnt = 0; mzero = 0; mid = 1;
  endtask

  task automatic prog(input logic [23:0] s);
    wr(4'h0, s[7:0]); wr(4'h1, s[15:8]); wr(4'hE, s[23:16]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [23:0] starts [6];
    starts[0] = 24'h000005; starts[1] = 24'h000001; starts[2] = 24'h000002;
    starts[3] = 24'h000100; starts[4] = 24'h12AB03; starts[5] = 24'h000000;
    mstart = '0;
    @(negedge clk);
    do_reset();

    // R11 reset state, R8 ID code after reset
    check_all("R11 R8 reset");
    // R12 unmapped address
    rd(4'h5, v); chk("R12 unmapped read", longint'(v), 0);
    // R1 programming start does not touch count; R5 high write ignored without features
    feat_en = 0; prog(24'h330201);
    check_all("R1 R5 write no load");
    chk("R5 id kept", longint'(mid), 1);
    feat_en = 1; wr(4'hE, 8'h04);
    check_all("R8 id cleared");

    // sweep: both feature settings, several lengths, all strobe mixes
    for (int f = 0; f < 2; f++) begin
      feat_en = f[0];
      for (int s = 0; s < 6; s++) begin
        prog(starts[s]);
        pulse(1, 1, 0, 0);
        check_all("R2 R4 R5 load");
        for (int k = 0; k < 8; k++) begin
          pulse(0, 0, k[0], k[1]);
          check_all("R3 R9 R7 step");
        end
      end
    end

    // R4 zero start means maximum
    feat_en = 1; prog(24'h0); pulse(1, 1, 0, 0);
    check_all("R4 max full");
    pulse(0, 0, 1, 0);
    check_all("R4 max full minus1");
    feat_en = 0; pulse(1, 1, 0, 0);
    check_all("R4 max base");
    pulse(0, 0, 1, 0);
    check_all("R4 max base minus1");

    // R9 saturation and R7 sticky flag, R2 plain command keeps flag
    feat_en = 1; prog(24'h000001); pulse(1, 1, 0, 0);
    pulse(0, 0, 1, 1);
    check_all("R9 saturate");
    pulse(0, 0, 0, 1);
    check_all("R7 flag holds");
    pulse(1, 0, 0, 0);
    check_all("R2 non-dma cmd");
    pulse(1, 1, 0, 0);
    check_all("R7 flag cleared by load");

    // R10 load beats decrement in the same cycle
    prog(24'h000010); pulse(1, 1, 1, 1);
    check_all("R10 load priority");

    // R6 start survives reset, R8 id returns
    prog(24'h000203);
    pulse(0, 0, 1, 1); pulse(0, 0, 1, 1); pulse(0, 0, 1, 1);
    pulse(0, 0, 1, 1); pulse(0, 0, 1, 1); pulse(0, 0, 1, 1);
    check_all("R7 reach zero before reset");
    do_reset();
    check_all("R11 R7 flag reset");
    pulse(1, 1, 0, 0);
    check_all("R6 reload after reset");
    chk("R6 value", mcnt, 64'h203);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule